// File: doc/BRIEF.md
# Asynchronous Host Bus Slave Interface

This block connects an asynchronous microprocessor bus, either 8 or 16 bits wide, to the internal side of a display controller. Two active-low chip selects choose between a small register window and a directly mapped memory window. The chip-select and strobe pins are brought into the core clock through synchronisers. Each strobe becomes exactly one request on a simple request/acknowledge port toward the core. The block steers byte lanes for the chosen bus width and returns read data on the pin bus.

Two handshake pins tell the processor when the access has finished. One is ready-style and the other is wait-style, and both are available at the same time. Each pin comes with a separate drive-enable output, so the pad ring can build the three-state behaviour. A level-only strap selects the bus width. In narrow mode the upper write strobe pin carries address bit 0. An interrupt output drives an open-drain pad low when a newly enabled status condition appears, and an acknowledged register-window access clears it.

Top module: `hostbus_if`

## Requirements
- R1: While reset is asserted and right after it, ready_oe_o, wait_oe_o, dbus_oe_o, irq_pull_o and core_req_o are all 0.
- R2: With both chip selects high, ready_oe_o and wait_oe_o are 0. With a chip select low and no strobe asserted, both enables are 1 and both ready_o and wait_o are 1.
- R3: Once a strobe is asserted under a chip select, ready_o stays 1 and wait_o is 0 until the core acknowledges. From the acknowledge until the strobe is removed, ready_o is 0 and wait_o is 1. The two pins are never both 0 while both are driven.
- R4: An access is recognised on the synchronised leading edge of a strobe and produces exactly one core_req_o. That request, with unchanged address and write flag, is held until core_ack_i. It drops in the cycle after the acknowledge.
- R5: In 16-bit mode (bus_wide_i=1), core_be_o bit 1 follows the upper write strobe (D15..8) and bit 0 follows the lower write strobe (D7..0). A read uses be 11. The byte address is {addr_i, 0}.
- R6: In 8-bit mode (bus_wide_i=0), the level of wr_hi_n_i is address bit 0 and only wr_lo_n_i strobes writes. D7..0 is copied onto both lanes with be 10 when bit 0 is 1 and be 01 when it is 0. A read returns the selected byte on D7..0 with D15..8 at 0.
- R7: With cs_reg_n_i low, core_space_o is 0 and core_addr_o keeps only its 4 low bits, whatever the upper address pins hold. With only cs_mem_n_i low, core_space_o is 1 and the full byte address passes. The register window wins if both selects are low.
- R8: dbus_oe_o is 1 only while rd_n_i and a chip select are both low. dbus_o carries the core_rdata_i value captured at the acknowledge of the read.
- R9: irq_pull_o becomes 1 after any status bit enabled by irq_enable_i rises. It stays 1 through memory-window accesses. It drops after the acknowledge of any register-window access, and it does not fire again while the status only stays high. A masked bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wide_i | input | 1 | Bus width strap, 1 = 16-bit, 0 = 8-bit |
| cs_reg_n_i | input | 1 | Register window select, active low |
| cs_mem_n_i | input | 1 | Memory window select, active low |
| wr_hi_n_i | input | 1 | Upper write strobe, or address bit 0 in 8-bit mode |
| wr_lo_n_i | input | 1 | Lower write strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| addr_i | input | 20 | Host address pins A20..A1 |
| dbus_i | input | 16 | Host data bus, input side |
| dbus_o | output | 16 | Host data bus, output side |
| dbus_oe_o | output | 1 | Data bus drive enable |
| ready_o | output | 1 | Ready pin level, 0 = access complete |
| ready_oe_o | output | 1 | Ready pin drive enable |
| wait_o | output | 1 | Wait pin level, 0 = hold the cycle |
| wait_oe_o | output | 1 | Wait pin drive enable |
| irq_pull_o | output | 1 | Open-drain interrupt, 1 = pull pad low |
| core_req_o | output | 1 | Access request to the core |
| core_we_o | output | 1 | Request is a write |
| core_space_o | output | 1 | 0 = register window, 1 = memory window |
| core_addr_o | output | 21 | Byte address of the request |
| core_wdata_o | output | 16 | Write data, lane steered |
| core_be_o | output | 2 | Byte enables, bit 1 = upper lane |
| core_ack_i | input | 1 | Core completes the pending request |
| core_rdata_i | input | 16 | Core read data, valid with the acknowledge |
| irq_status_i | input | 4 | Internal status conditions |
| irq_enable_i | input | 4 | Per-bit interrupt enables |

## Verification
The hardest state to reach from the pins is a strobe that has been recognised and is waiting on a core that has not answered. Only in that state can the busy levels of the two handshake pins be seen. The bench's core model has a hold switch that withholds the acknowledge. A vector row keeps it closed while the strobe is held, samples both pins, and then opens it so the stalled request drains before the next row. A second hard case is an interrupt that is pending while memory-window traffic runs. The bench raises an enabled status bit, runs a memory read, and only then runs a register read to clear it.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DONE = 2'd2
    } hbi_state_e;

    localparam logic SPACE_REG = 1'b0;
    localparam logic SPACE_MEM = 1'b1;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int   W      = 1,
    parameter int   STAGES = 2,
    parameter logic RST    = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES:0][W-1:0] chain;

    assign chain[0] = din;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g+1] <= {W{RST}};
            else        chain[g+1] <= chain[g];
        end
    end

    assign dout = chain[STAGES];
endmodule

// File: rtl/hbi_lane.sv
module hbi_lane #(
    parameter int AW  = 20,
    parameter int DW  = 16,
    parameter int WIN = 4
) (
    input  logic          wide,
    input  logic          is_reg,
    input  logic          is_read,
    input  logic          wr_hi_n,
    input  logic          wr_lo_n,
    input  logic [AW:1]   addr,
    input  logic [DW-1:0] din,
    output logic [AW:0]   byte_addr,
    output logic [DW-1:0] wdata,
    output logic [1:0]    be
);
    localparam int BW = DW / 2;
    localparam logic [AW:0] WIN_MASK = {{(AW + 1 - WIN){1'b0}}, {WIN{1'b1}}};

    logic          a0;
    logic [AW:0]   full;

    always_comb begin
        a0        = wide ? 1'b0 : wr_hi_n;
        full      = {addr, a0};
        byte_addr = is_reg ? (full & WIN_MASK) : full;
        if (wide) begin
            wdata = din;
            be    = is_read ? 2'b11 : {~wr_hi_n, ~wr_lo_n};
        end else begin
            wdata = {din[BW-1:0], din[BW-1:0]};
            be    = a0 ? 2'b10 : 2'b01;
        end
    end
endmodule

// File: rtl/hbi_irq.sv
module hbi_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] status,
    input  logic [N-1:0] enable,
    input  logic         clear,
    output logic         pull
);
    typedef struct packed {
        logic hit;
        logic pend;
    } irq_t;

    irq_t q, d;

    always_comb begin
        d.hit  = |(status & enable);
        d.pend = (q.pend | (d.hit & ~q.hit)) & ~clear;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pull = q.pend;
endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
    import hbi_pkg::*;
#(
    parameter int AW    = 20,
    parameter int DW    = 16,
    parameter int WIN   = 4,
    parameter int SYNC  = 2,
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wide_i,
    input  logic             cs_reg_n_i,
    input  logic             cs_mem_n_i,
    input  logic             wr_hi_n_i,
    input  logic             wr_lo_n_i,
    input  logic             rd_n_i,
    input  logic [AW:1]      addr_i,
    input  logic [DW-1:0]    dbus_i,
    output logic [DW-1:0]    dbus_o,
    output logic             dbus_oe_o,
    output logic             ready_o,
    output logic             ready_oe_o,
    output logic             wait_o,
    output logic             wait_oe_o,
    output logic             irq_pull_o,
    output logic             core_req_o,
    output logic             core_we_o,
    output logic             core_space_o,
    output logic [AW:0]      core_addr_o,
    output logic [DW-1:0]    core_wdata_o,
    output logic [1:0]       core_be_o,
    input  logic             core_ack_i,
    input  logic [DW-1:0]    core_rdata_i,
    input  logic [IRQ_W-1:0] irq_status_i,
    input  logic [IRQ_W-1:0] irq_enable_i
);
    localparam int BW = DW / 2;

    typedef struct packed {
        hbi_state_e    st;
        logic          strb;
        logic          req;
        logic          we;
        logic          space;
        logic          lsb;
        logic [AW:0]   addr;
        logic [DW-1:0] wdata;
        logic [1:0]    be;
        logic [DW-1:0] rdata;
    } ctl_t;

    ctl_t q, d;

    // synchronised pin copies: {cs_reg, cs_mem, rd, wr_hi, wr_lo}
    logic [4:0] pins_s;
    logic s_cs_reg_n, s_cs_mem_n, s_rd_n, s_wr_hi_n, s_wr_lo_n;
    logic sel_s, strb_s, sel_raw, strb_raw, irq_clr;
    logic [AW:0]   ln_addr;
    logic [DW-1:0] ln_wdata;
    logic [1:0]    ln_be;
    logic [DW-1:0] rd_steer;

    hbi_sync #(.W(5), .STAGES(SYNC), .RST(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_reg_n_i, cs_mem_n_i, rd_n_i, wr_hi_n_i, wr_lo_n_i}),
        .dout (pins_s)
    );

    assign {s_cs_reg_n, s_cs_mem_n, s_rd_n, s_wr_hi_n, s_wr_lo_n} = pins_s;

    assign sel_s    = ~s_cs_reg_n | ~s_cs_mem_n;
    assign strb_s   = ~s_rd_n | ~s_wr_lo_n | (bus_wide_i & ~s_wr_hi_n);
    assign sel_raw  = ~cs_reg_n_i | ~cs_mem_n_i;
    assign strb_raw = ~rd_n_i | ~wr_lo_n_i | (bus_wide_i & ~wr_hi_n_i);

    hbi_lane #(.AW(AW), .DW(DW), .WIN(WIN)) u_lane (
        .wide     (bus_wide_i),
        .is_reg   (~s_cs_reg_n),
        .is_read  (~s_rd_n),
        .wr_hi_n  (wr_hi_n_i),
        .wr_lo_n  (wr_lo_n_i),
        .addr     (addr_i),
        .din      (dbus_i),
        .byte_addr(ln_addr),
        .wdata    (ln_wdata),
        .be       (ln_be)
    );

    always_comb begin
        if (bus_wide_i) rd_steer = core_rdata_i;
        else            rd_steer = {{BW{1'b0}}, q.lsb ? core_rdata_i[DW-1:BW]
                                                      : core_rdata_i[BW-1:0]};
    end

    always_comb begin
        d       = q;
        d.strb  = strb_s;
        irq_clr = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (sel_s && strb_s && !q.strb) begin
                    d.st    = ST_REQ;
                    d.req   = 1'b1;
                    d.we    = s_rd_n;
                    d.space = s_cs_reg_n ? SPACE_MEM : SPACE_REG;
                    d.addr  = ln_addr;
                    d.lsb   = ln_addr[0];
                    d.wdata = ln_wdata;
                    d.be    = ln_be;
                end
            end
            ST_REQ: begin
                if (core_ack_i) begin
                    d.st    = ST_DONE;
                    d.req   = 1'b0;
                    irq_clr = (q.space == SPACE_REG);
                    if (!q.we) d.rdata = rd_steer;
                end
            end
            ST_DONE: begin
                if (!strb_s) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    hbi_irq #(.N(IRQ_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .status(irq_status_i),
        .enable(irq_enable_i),
        .clear (irq_clr),
        .pull  (irq_pull_o)
    );

    assign ready_oe_o   = sel_raw;
    assign wait_oe_o    = sel_raw;
    assign ready_o      = ~(strb_raw & (q.st == ST_DONE));
    assign wait_o       = ~(strb_raw & (q.st != ST_DONE));
    assign dbus_oe_o    = sel_raw & ~rd_n_i;
    assign dbus_o       = q.rdata;
    assign core_req_o   = q.req;
    assign core_we_o    = q.we;
    assign core_space_o = q.space;
    assign core_addr_o  = q.addr;
    assign core_wdata_o = q.wdata;
    assign core_be_o    = q.be;
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
    parameter int AW = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ready_o,
    input logic        ready_oe_o,
    input logic        wait_o,
    input logic        wait_oe_o,
    input logic        dbus_oe_o,
    input logic        irq_pull_o,
    input logic        core_req_o,
    input logic        core_we_o,
    input logic        core_space_o,
    input logic [AW:0] core_addr_o,
    input logic        core_ack_i
);
    // R3: the two handshake pins never both assert while driven
    a_r3_pins_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_oe_o && wait_oe_o) |-> (ready_o || wait_o));

    // R4: an unanswered request stays up
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_o && !core_ack_i) |=> core_req_o);

    // R4: request fields do not move while waiting
    a_r4_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_o && !core_ack_i) |=> ($stable(core_addr_o) && $stable(core_we_o)));

    // R4: one request per strobe, dropped after the acknowledge
    a_r4_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_o && core_ack_i) |=> !core_req_o);

    // R9: a register-window acknowledge clears the interrupt
    a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_o && core_ack_i && !core_space_o) |=> !irq_pull_o);

    // R8: no data drive while the chip is not selected
    a_r8_no_drive_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_oe_o |-> !dbus_oe_o);
endmodule

bind hostbus_if hbi_checker #(.AW(AW)) u_hbi_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_o     (ready_o),
    .ready_oe_o  (ready_oe_o),
    .wait_o      (wait_o),
    .wait_oe_o   (wait_oe_o),
    .dbus_oe_o   (dbus_oe_o),
    .irq_pull_o  (irq_pull_o),
    .core_req_o  (core_req_o),
    .core_we_o   (core_we_o),
    .core_space_o(core_space_o),
    .core_addr_o (core_addr_o),
    .core_ack_i  (core_ack_i)
);

// File: tb/tb_hostbus_if.sv
`timescale 1ns/100ps
module tb_hostbus_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wide = 1'b1;
    logic        cs_reg_n = 1'b1, cs_mem_n = 1'b1;
    logic        wr_hi_n = 1'b1, wr_lo_n = 1'b1, rd_n = 1'b1;
    logic [20:1] addr_p = '0;
    logic [15:0] din = '0;
    logic [15:0] dbus_o;
    logic        dbus_oe, ready_o, ready_oe, wait_o, wait_oe, irq_pull;
    logic        core_req, core_we, core_space;
    logic [20:0] core_addr;
    logic [15:0] core_wdata;
    logic [1:0]  core_be;
    logic        core_ack = 1'b0;
    logic [15:0] core_rdata;
    logic [3:0]  irq_status = '0, irq_enable = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hostbus_if dut (
        .clk(clk), .rst_n(rst_n), .bus_wide_i(bus_wide),
        .cs_reg_n_i(cs_reg_n), .cs_mem_n_i(cs_mem_n),
        .wr_hi_n_i(wr_hi_n), .wr_lo_n_i(wr_lo_n), .rd_n_i(rd_n),
        .addr_i(addr_p), .dbus_i(din),
        .dbus_o(dbus_o), .dbus_oe_o(dbus_oe),
        .ready_o(ready_o), .ready_oe_o(ready_oe),
        .wait_o(wait_o), .wait_oe_o(wait_oe), .irq_pull_o(irq_pull),
        .core_req_o(core_req), .core_we_o(core_we), .core_space_o(core_space),
        .core_addr_o(core_addr), .core_wdata_o(core_wdata), .core_be_o(core_be),
        .core_ack_i(core_ack), .core_rdata_i(core_rdata),
        .irq_status_i(irq_status), .irq_enable_i(irq_enable)
    );

    // core model: 32 words indexed by {space, addr[4:1]}
    logic [15:0] mdl [32];
    logic        hold_ack = 1'b0;
    logic [20:0] last_addr = '0;
    logic [1:0]  last_be = '0;
    logic        last_space = 1'b0;

    assign core_rdata = mdl[{core_space, core_addr[4:1]}];

    initial for (int i = 0; i < 32; i++) mdl[i] = '0;

    always @(posedge clk) begin
        core_ack <= 1'b0;
        if (core_req && !core_ack && !hold_ack) begin
            core_ack   <= 1'b1;
            last_addr  <= core_addr;
            last_be    <= core_be;
            last_space <= core_space;
            if (core_we) begin
                if (core_be[1]) mdl[{core_space, core_addr[4:1]}][15:8] <= core_wdata[15:8];
                if (core_be[0]) mdl[{core_space, core_addr[4:1]}][7:0]  <= core_wdata[7:0];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one bus access; a0pin is the wr_hi_n level in 8-bit mode
    task automatic access(input logic is_reg, input logic is_read, input logic hi,
                          input logic lo, input logic a0pin, input logic [20:1] a,
                          input logic [15:0] data, output logic [15:0] rdv,
                          output logic oe_seen);
        int n;
        @(negedge clk);
        addr_p = a;
        din = data;
        wr_hi_n = bus_wide ? 1'b1 : a0pin;
        cs_reg_n = ~is_reg;
        cs_mem_n = is_reg;
        @(negedge clk);
        rd_n = ~is_read;
        if (bus_wide) wr_hi_n = ~hi;
        wr_lo_n = ~lo;
        n = 0;
        while (ready_o !== 1'b0 && n < 100) begin
            @(negedge clk);
            n++;
        end
        if (n >= 100) chk("R3 access timeout", 0, 1);
        rdv = dbus_o;
        oe_seen = dbus_oe;
        @(negedge clk);
        rd_n = 1'b1;
        wr_lo_n = 1'b1;
        if (bus_wide) wr_hi_n = 1'b1;
        @(negedge clk);
        cs_reg_n = 1'b1;
        cs_mem_n = 1'b1;
        wr_hi_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // {cs_reg, cs_mem, rd, hold, exp_ready_oe, exp_ready, exp_wait_oe, exp_wait}
    localparam logic [7:0] VEC [6] = '{
        8'b0000_0101,
        8'b1000_1111,
        8'b0100_1111,
        8'b1011_1110,
        8'b1010_1011,
        8'b0110_1011
    };

    initial begin
        logic [15:0] rv;
        logic        oe;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready_oe", ready_oe, 0);
        chk("R1 wait_oe", wait_oe, 0);
        chk("R1 dbus_oe", dbus_oe, 0);
        chk("R1 irq_pull", irq_pull, 0);
        chk("R1 core_req", core_req, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 core_req after reset", core_req, 0);

        // R2/R3: handshake levels table
        foreach (VEC[i]) begin
            hold_ack = VEC[i][4];
            cs_reg_n = ~VEC[i][7];
            cs_mem_n = ~VEC[i][6];
            @(negedge clk);
            rd_n = ~VEC[i][5];
            repeat (10) @(negedge clk);
            chk($sformatf("R2 R3 vec%0d ready_oe", i), ready_oe, VEC[i][3]);
            chk($sformatf("R2 R3 vec%0d wait_oe", i), wait_oe, VEC[i][1]);
            if (VEC[i][3]) begin
                chk($sformatf("R2 R3 vec%0d ready", i), ready_o, VEC[i][2]);
                chk($sformatf("R2 R3 vec%0d wait", i), wait_o, VEC[i][0]);
            end
            rd_n = 1'b1;
            hold_ack = 1'b0;
            @(negedge clk);
            cs_reg_n = 1'b1;
            cs_mem_n = 1'b1;
            repeat (10) @(negedge clk);
        end

        // R5: 16-bit write, both lanes, register byte 6
        access(1, 0, 1, 1, 0, 20'h00003, 16'hBEEF, rv, oe);
        chk("R5 be both", last_be, 2'b11);
        chk("R5 addr", last_addr, 21'h6);
        chk("R8 no drive on write", oe, 0);
        access(1, 1, 0, 0, 0, 20'h00003, 16'h0, rv, oe);
        chk("R8 read data", rv, 16'hBEEF);
        chk("R8 drive on read", oe, 1);
        chk("R5 read be", last_be, 2'b11);
        chk("R8 released after read", dbus_oe, 0);
        // R5: upper lane only
        access(1, 0, 1, 0, 0, 20'h00003, 16'h12AB, rv, oe);
        chk("R5 be upper", last_be, 2'b10);
        access(1, 1, 0, 0, 0, 20'h00003, 16'h0, rv, oe);
        chk("R5 upper lane merge", rv, 16'h12EF);

        // R7: window decode
        access(1, 0, 1, 1, 0, 20'hFFFF3, 16'h7777, rv, oe);
        chk("R7 reg addr masked", last_addr, 21'h6);
        chk("R7 reg space", last_space, 0);
        access(0, 0, 1, 1, 0, 20'h12345, 16'hCAFE, rv, oe);
        chk("R7 mem addr full", last_addr, 21'h2468A);
        chk("R7 mem space", last_space, 1);
        access(0, 1, 0, 0, 0, 20'h12345, 16'h0, rv, oe);
        chk("R7 mem readback", rv, 16'hCAFE);

        // R6: 8-bit mode
        bus_wide = 1'b0;
        access(1, 0, 0, 1, 1, 20'h00002, 16'h005A, rv, oe);
        chk("R6 narrow be a0=1", last_be, 2'b10);
        chk("R6 narrow addr a0=1", last_addr, 21'h5);
        access(1, 0, 0, 1, 0, 20'h00002, 16'h0033, rv, oe);
        chk("R6 narrow be a0=0", last_be, 2'b01);
        access(1, 1, 0, 0, 1, 20'h00002, 16'h0, rv, oe);
        chk("R6 narrow read hi byte", rv, 16'h005A);
        access(1, 1, 0, 0, 0, 20'h00002, 16'h0, rv, oe);
        chk("R6 narrow read lo byte", rv, 16'h0033);
        bus_wide = 1'b1;
        access(1, 1, 0, 0, 0, 20'h00002, 16'h0, rv, oe);
        chk("R6 wide view of narrow writes", rv, 16'h5A33);

        // R9: interrupt
        irq_enable = 4'b0010;
        @(negedge clk);
        irq_status = 4'b0001;
        repeat (4) @(negedge clk);
        chk("R9 masked bit ignored", irq_pull, 0);
        irq_status = 4'b0011;
        repeat (4) @(negedge clk);
        chk("R9 irq raised", irq_pull, 1);
        access(0, 1, 0, 0, 0, 20'h00010, 16'h0, rv, oe);
        chk("R9 mem access keeps irq", irq_pull, 1);
        access(1, 1, 0, 0, 0, 20'h00001, 16'h0, rv, oe);
        chk("R9 reg access clears irq", irq_pull, 0);
        repeat (6) @(negedge clk);
        chk("R9 level does not refire", irq_pull, 0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule